// File: doc/BRIEF.md
# Dual-Issue Pairing Decision

This block sits in the issue stage of an in-order core that has two execution pipes. Each cycle it looks at the two oldest decoded instructions and decides how many of them leave the queue. For each instruction it receives a class tag (integer ALU, memory access, branch/jump) and its register specifiers. It then says which pipe slots carry an instruction this cycle and how many instructions were consumed.

The older instruction normally takes pipe 0 and the younger one pipe 1. A younger instruction that reads the older one's result cannot go with it; it waits and becomes the older instruction of the next pair. A mode input chooses between two pairing policies. In the restricted policy, pipe 0 cannot run memory accesses and pipe 1 cannot run branches. In the unrestricted policy, any classes may pair. The decision is combinational from the inputs. The clock and reset only gate issue and time the checks.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst_n` is low, `pipe0_go`, `pipe1_go` and `pipe1_old` are 0 and `issue_cnt` is 0.
- R2: While `stall` is 1, nothing issues and `issue_cnt` is 0.
- R3: When `old_vld` is 0, nothing issues and `issue_cnt` is 0, whatever the younger inputs are.
- R4: When both instructions issue, the older is in pipe 0 and the younger in pipe 1 (`pipe1_old` = 0). The younger never issues without the older.
- R5: In restricted mode (`mode_free` = 0), a younger branch/jump (class 2'b10) never pairs. Only the older instruction issues, in pipe 0.
- R6: In restricted mode, an older memory instruction (class 2'b01) issues alone in pipe 1. In that case `pipe0_go`=0, `pipe1_go`=1, `pipe1_old`=1 and `issue_cnt`=1.
- R7: If `old_dst` is nonzero and equals `yng_src_a` or `yng_src_b`, only the older instruction issues (in pipe 0, `issue_cnt`=1).
- R8: An `old_dst` of 0 never creates a dependence, even when it matches a younger source.
- R9: In unrestricted mode (`mode_free` = 1), any class combination pairs when the younger is valid and independent, with `issue_cnt`=2.
- R10: `issue_cnt` always equals the number of asserted pipe go signals.
- R11: Class code 2'b11 is handled exactly like integer ALU (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (times assertions) |
| rst_n | input | 1 | Synchronous active-low reset; blocks issue |
| mode_free | input | 1 | 1 = unrestricted pairing, 0 = restricted |
| stall | input | 1 | Blocks all issue this cycle |
| old_vld | input | 1 | Older instruction present |
| old_cls | input | 2 | Older class: 00 ALU, 01 memory, 10 branch/jump, 11 as ALU |
| old_dst | input | 5 | Older destination register |
| yng_vld | input | 1 | Younger instruction present |
| yng_cls | input | 2 | Younger class, same encoding |
| yng_src_a | input | 5 | Younger first source register |
| yng_src_b | input | 5 | Younger second source register |
| pipe0_go | output | 1 | Pipe 0 receives the older instruction |
| pipe1_go | output | 1 | Pipe 1 receives an instruction |
| pipe1_old | output | 1 | Pipe 1 carries the older instruction (not the younger) |
| issue_cnt | output | 2 | Instructions consumed this cycle |

## Verification
The hardest case to produce is the overlap of several blocking conditions. Examples are a dependence through register 0 while a younger branch is present in restricted mode, or an older memory instruction together with an independent younger one. In each overlap the most specific rule has to win. The stimulus reaches every overlap by sweeping every combination of mode, stall, both valids, all four class codes of each instruction, and register numbers 0 to 3 for the destination and both sources. This covers matches on either source, on both, and through register 0.

// File: rtl/dual_issue_pkg.sv
// Shared class encoding and register width for the pairing logic.
package dual_issue_pkg;
    parameter int REG_W = 5;
    parameter int SRC_N = 2;
    parameter int CNT_W = 2;

    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_MEM = 2'b01,
        CLS_BR  = 2'b10,
        CLS_ALT = 2'b11
    } ins_cls_t;

    // Fold the spare code onto integer ALU.
    function automatic ins_cls_t norm_cls(input logic [1:0] raw);
        return (raw == 2'b11) ? CLS_ALU : ins_cls_t'(raw);
    endfunction
endpackage

// File: rtl/dep_check.sv
// Read-after-write test of the younger instruction against the older one.
// Assumes register 0 is a constant and never carries a dependence.
module dual_issue_dep_check #(
    parameter int REG_W = 5,
    parameter int SRC_N = 2
) (
    input  logic [REG_W-1:0]       prod_dst,
    input  logic [SRC_N*REG_W-1:0] cons_srcs,
    output logic                   depends
);
    logic [SRC_N-1:0] hit;

    // One comparator per source specifier.
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        assign hit[s] = (cons_srcs[s*REG_W +: REG_W] == prod_dst);
    end

    // A match only counts for a real destination register.
    always_comb begin
        depends = (prod_dst != '0) && (|hit);
    end
endmodule

// File: rtl/slot_rules.sv
// Pipe legality by class under the selected pairing policy.
// Assumes the classes have already been folded by norm_cls.
module dual_issue_slot_rules
    import dual_issue_pkg::*;
(
    input  logic     mode_free,
    input  ins_cls_t old_c,
    input  ins_cls_t yng_c,
    output logic     old_needs_p1,
    output logic     yng_p1_ok
);
    // Restricted policy: memory only in pipe 1, branches only in pipe 0.
    always_comb begin
        old_needs_p1 = !mode_free && (old_c == CLS_MEM);
        yng_p1_ok    = mode_free || (yng_c != CLS_BR);
    end
endmodule

// File: rtl/dual_issue_pair.sv
// Top of the issue-pair decision. Combinational from the inputs; the
// clock times the assertions and the synchronous reset level gates issue.
module dual_issue_pair
    import dual_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_free,
    input  logic             stall,
    input  logic             old_vld,
    input  logic [1:0]       old_cls,
    input  logic [REG_W-1:0] old_dst,
    input  logic             yng_vld,
    input  logic [1:0]       yng_cls,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic [REG_W-1:0] yng_src_b,
    output logic             pipe0_go,
    output logic             pipe1_go,
    output logic             pipe1_old,
    output logic [CNT_W-1:0] issue_cnt
);
    ins_cls_t old_c, yng_c;
    logic     old_needs_p1, yng_p1_ok, depends, can_issue, pair_ok;

    assign old_c = norm_cls(old_cls);
    assign yng_c = norm_cls(yng_cls);

    dual_issue_dep_check #(.REG_W(REG_W), .SRC_N(SRC_N)) u_dep (
        .prod_dst  (old_dst),
        .cons_srcs ({yng_src_b, yng_src_a}),
        .depends   (depends)
    );

    dual_issue_slot_rules u_rules (
        .mode_free    (mode_free),
        .old_c        (old_c),
        .yng_c        (yng_c),
        .old_needs_p1 (old_needs_p1),
        .yng_p1_ok    (yng_p1_ok)
    );

    // Issue decision: the older goes first, the younger joins only if legal.
    always_comb begin
        can_issue = rst_n && !stall && old_vld;
        pair_ok   = yng_vld && !depends && yng_p1_ok && !old_needs_p1;
        pipe0_go  = can_issue && !old_needs_p1;
        pipe1_old = can_issue && old_needs_p1;
        pipe1_go  = pipe1_old || (pipe0_go && pair_ok);
        issue_cnt = CNT_W'(pipe0_go) + CNT_W'(pipe1_go);
    end

    p_stall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (issue_cnt == '0 && !pipe0_go && !pipe1_go));

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe0_go && pipe1_go) |-> !pipe1_old);

    p_branch_p0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_free && pipe1_go && !pipe1_old) |-> (yng_cls != 2'b10));

    p_mem_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_free && !stall && old_vld && old_cls == 2'b01)
            |-> (pipe1_go && pipe1_old && !pipe0_go));

    p_dep_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe0_go && old_dst != '0 &&
         (old_dst == yng_src_a || old_dst == yng_src_b)) |-> !pipe1_go);

    p_cnt_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pipe0_go, pipe1_go}) == int'(issue_cnt));
endmodule

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       mode_free = 0, stall = 0, old_vld = 0, yng_vld = 0;
    logic [1:0] old_cls = 0, yng_cls = 0;
    logic [4:0] old_dst = 0, yng_src_a = 0, yng_src_b = 0;
    logic       pipe0_go, pipe1_go, pipe1_old;
    logic [1:0] issue_cnt;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_issue_pair u_dut (
        .clk(clk), .rst_n(rst_n), .mode_free(mode_free), .stall(stall),
        .old_vld(old_vld), .old_cls(old_cls), .old_dst(old_dst),
        .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_src_a(yng_src_a),
        .yng_src_b(yng_src_b), .pipe0_go(pipe0_go), .pipe1_go(pipe1_go),
        .pipe1_old(pipe1_old), .issue_cnt(issue_cnt)
    );

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b (p0 p1 p1old cnt) mode=%0b st=%0b ov=%0b yv=%0b oc=%0d yc=%0d d=%0d a=%0d b=%0d",
                     tag, got, exp, mode_free, stall, old_vld, yng_vld,
                     old_cls, yng_cls, old_dst, yng_src_a, yng_src_b);
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] exp;
        logic       p0, p1, po, dep, match, pr;
        logic [1:0] oc, yc;
        string      tag;
        // R1: issue blocked while reset is held
        old_vld = 1; yng_vld = 1; mode_free = 1;
        repeat (3) @(negedge clk);
        #1 check("R1", {pipe0_go, pipe1_go, pipe1_old, issue_cnt}, 5'b0);
        @(negedge clk); rst_n = 1;
        for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
        for (int ov = 0; ov < 2; ov++)
        for (int yv = 0; yv < 2; yv++)
        for (int c0 = 0; c0 < 4; c0++)
        for (int c1 = 0; c1 < 4; c1++)
        for (int d = 0; d < 4; d++)
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            mode_free = m[0]; stall = s[0]; old_vld = ov[0]; yng_vld = yv[0];
            old_cls = c0[1:0]; yng_cls = c1[1:0];
            old_dst = d[4:0]; yng_src_a = a[4:0]; yng_src_b = b[4:0];
            #1;
            oc = (c0 == 3) ? 2'd0 : c0[1:0];
            yc = (c1 == 3) ? 2'd0 : c1[1:0];
            match = (d == a) || (d == b);
            dep = (d != 0) && match;
            p0 = 0; p1 = 0; po = 0;
            if (s != 0) tag = "R2";
            else if (ov == 0) tag = "R3";
            else if (m == 0 && oc == 2'd1) begin
                p1 = 1; po = 1; tag = "R6";
            end else begin
                p0 = 1;
                pr = (yv != 0) && !dep && (m == 1 || yc != 2'd2);
                p1 = pr;
                if (dep) tag = "R7";
                else if (match && yv != 0) tag = "R8";
                else if (m == 0 && yc == 2'd2) tag = "R5";
                else if (m == 1) tag = "R9";
                else if (c0 == 3 || c1 == 3) tag = "R11";
                else tag = "R4";
            end
            exp = {p0, p1, po, 2'(p0) + 2'(p1)};
            check(tag, {pipe0_go, pipe1_go, pipe1_old, issue_cnt}, exp);
            // R10: count agrees with the go signals
            check("R10", {3'b0, issue_cnt}, {3'b0, 2'(pipe0_go) + 2'(pipe1_go)});
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule